// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog whose arming is guarded by a full key byte rather than a single enable bit. Software writes a key byte into a control field; one exact value arms the watchdog and loads its countdown, a second exact value drives an auxiliary enable output instead, and any other value drops both at once. The countdown runs in coarse units, each unit being a fixed number of system clocks set by a module parameter, and its length in units comes from an 8-bit period field in which zero is replaced by a minimum of seven.

While armed, software restarts the countdown by pulsing a kick strobe. If the countdown reaches its end without a kick, the block raises a reset request for a parameterised number of clocks and disarms itself; it stays disarmed until the arming key is written again. The register transport that produces the write strobes and whatever the reset request drives both sit outside the block.

Top module: `kwdt_top`

## Requirements
- R1: After reset `wd_armed`, `aux_enable` and `reset_req` are all 0, the stored key is 0x00 and the stored period is 0x00.
- R2: A key write of 0xA5 arms the watchdog on the next clock and starts a full countdown; a write of 0xA5 while already armed restarts the full countdown from that write.
- R3: A key write of 0xE5 sets `aux_enable` to 1 on the next clock and leaves `wd_armed` at 0.
- R4: A key write of any value other than 0xA5 clears `wd_armed` on the next clock (no reset request follows), and any value other than 0xE5 clears `aux_enable`.
- R5: With period value P (nonzero) and unit length D clocks, `reset_req` rises exactly P*D clocks after the arming edge when no kick occurs.
- R6: A period value of 0x00 gives a countdown of 7 units.
- R7: A kick while armed restarts the full countdown from the kick edge; a kick while disarmed has no effect on any output.
- R8: On expiry `reset_req` stays high for exactly HOLD_CYCLES clocks, `wd_armed` falls on the same edge, and no further reset request occurs until 0xA5 is written again.
- R9: A period write while armed does not alter the countdown in progress; the new value is used from the next arming or kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_wr | input | 1 | Strobe: write `key_data` into the key byte |
| key_data | input | 8 | Key byte value |
| period_wr | input | 1 | Strobe: write `period_data` into the period field |
| period_data | input | 8 | Countdown length in units, 0 means 7 |
| kick | input | 1 | Strobe: one-cycle write of 1 to the kick bit |
| wd_armed | output | 1 | Watchdog is counting |
| aux_enable | output | 1 | Auxiliary enable selected by the second key |
| reset_req | output | 1 | Reset request, high for HOLD_CYCLES clocks after expiry |

## Verification
The countdown is driven with a mid-range period, a zero period and a period rewritten mid-count, so the cycle at which the reset request rises tells apart a correct unit count, the minimum substitution and a period register wrongly read live. Kicks given while armed and while disarmed, and a second arming write during a count, separate a true restart from an ignored strobe or a doubly counted one. Key values of 0xA5, 0xE5, 0x00 and 0x3C show that only the exact bytes act and that any other byte disarms at once, and the width of every reset pulse plus the absence of unexpected pulses after expiry check the hold time and the self-disarm.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
   localparam int KEY_W = 8;
   localparam int PER_W = 8;
   localparam logic [KEY_W-1:0] KEY_ARM = 8'hA5;
   localparam logic [KEY_W-1:0] KEY_AUX = 8'hE5;
   localparam logic [PER_W-1:0] PER_MIN = 8'h07;

   function automatic logic [PER_W-1:0] eff_period(input logic [PER_W-1:0] p);
      return (p == '0) ? PER_MIN : p;
   endfunction
endpackage

// File: rtl/kwdt_key_decode.sv
module kwdt_key_decode
   import kwdt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_wr,
   input  logic [KEY_W-1:0] key_data,
   input  logic             expire,
   output logic             armed,
   output logic             aux_en,
   output logic             arm_load
);
   logic [KEY_W-1:0] key_q;

   assign arm_load = key_wr && (key_data == KEY_ARM);
   assign aux_en   = (key_q == KEY_AUX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= '0;
         armed <= 1'b0;
      end else if (key_wr) begin
         key_q <= key_data;
         armed <= (key_data == KEY_ARM);
      end else if (expire) begin
         armed <= 1'b0;
      end
   end
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         logic [PRE_W-1:0] pre_q;
         assign tick = run && (pre_q == PRE_W'(DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 pre_q <= '0;
            else if (restart || !run)   pre_q <= '0;
            else if (tick)              pre_q <= '0;
            else                        pre_q <= pre_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/kwdt_countdown.sv
module kwdt_countdown
   import kwdt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             armed,
   input  logic             reload,
   input  logic             cancel,
   input  logic             tick,
   input  logic [PER_W-1:0] period,
   output logic             expire
);
   logic [PER_W-1:0] cnt_q;

   assign expire = armed && tick && !reload && !cancel && (cnt_q == PER_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (reload)                 cnt_q <= eff_period(period);
      else if (armed && tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/kwdt_stretch.sv
module kwdt_stretch #(
   parameter int HOLD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic pulse
);
   localparam int H_W = (HOLD > 1) ? $clog2(HOLD) : 1;
   logic [H_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse  <= 1'b0;
         left_q <= '0;
      end else if (fire) begin
         pulse  <= 1'b1;
         left_q <= H_W'(HOLD - 1);
      end else if (pulse) begin
         if (left_q == '0) pulse <= 1'b0;
         else              left_q <= left_q - 1'b1;
      end
   end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
   import kwdt_pkg::*;
#(
   parameter int PRE_DIV     = 1000,
   parameter int HOLD_CYCLES = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       key_wr,
   input  logic [7:0] key_data,
   input  logic       period_wr,
   input  logic [7:0] period_data,
   input  logic       kick,
   output logic       wd_armed,
   output logic       aux_enable,
   output logic       reset_req
);
   generate
      if (PRE_DIV < 1) begin : g_bad_div
         $error("kwdt_top: PRE_DIV must be at least 1");
      end
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("kwdt_top: HOLD_CYCLES must be at least 1");
      end
   endgenerate

   logic             arm_load, expire, tick, reload;
   logic [PER_W-1:0] period_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         period_q <= '0;
      else if (period_wr) period_q <= period_data;
   end

   assign reload = arm_load || (kick && wd_armed);

   kwdt_key_decode u_key (
      .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(key_data),
      .expire(expire), .armed(wd_armed), .aux_en(aux_enable), .arm_load(arm_load)
   );

   kwdt_prescaler #(.DIV(PRE_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(wd_armed), .restart(reload), .tick(tick)
   );

   kwdt_countdown u_cnt (
      .clk(clk), .rst_n(rst_n), .armed(wd_armed), .reload(reload),
      .cancel(key_wr), .tick(tick), .period(period_q), .expire(expire)
   );

   kwdt_stretch #(.HOLD(HOLD_CYCLES)) u_hold (
      .clk(clk), .rst_n(rst_n), .fire(expire), .pulse(reset_req)
   );
endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       key_wr,
   input logic [7:0] key_data,
   input logic       kick,
   input logic       wd_armed,
   input logic       aux_enable,
   input logic       reset_req
);
   assert_arm_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && key_data == 8'hA5) |=> wd_armed);

   assert_aux_not_armed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && key_data == 8'hE5) |=> (aux_enable && !wd_armed));

   assert_other_key_disarms_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr && key_data != 8'hA5) |=> !wd_armed);

   assert_kick_no_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_armed && kick && !key_wr) |=> !$rose(reset_req));

   assert_expiry_from_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reset_req) |-> ($past(wd_armed) && !wd_armed));

   assert_exclusive_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wd_armed && aux_enable));
endmodule

bind kwdt_top kwdt_checker u_chk (
   .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(key_data), .kick(kick),
   .wd_armed(wd_armed), .aux_enable(aux_enable), .reset_req(reset_req)
);

// File: tb/kwdt_top_test.sv
module kwdt_top_test;
   localparam int CLK_PERIOD = 10;
   localparam int PRE  = 4;
   localparam int HOLD = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic key_wr = 1'b0, period_wr = 1'b0, kick = 1'b0;
   logic [7:0] key_data = '0, period_data = '0;
   logic wd_armed, aux_enable, reset_req;

   int n_chk = 0, n_bad = 0, cyc = 0;
   int exp_q[$];
   string tag_q[$];
   bit prev = 1'b0;
   int width = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   kwdt_top #(.PRE_DIV(PRE), .HOLD_CYCLES(HOLD)) uut (
      .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(key_data),
      .period_wr(period_wr), .period_data(period_data), .kick(kick),
      .wd_armed(wd_armed), .aux_enable(aux_enable), .reset_req(reset_req)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor: pops expected rise cycles, checks pulse width
   always @(negedge clk) if (rst_n) begin
      if (reset_req && !prev) begin
         if (exp_q.size() == 0) chk(1'b0, "R8 unexpected reset request", cyc, -1);
         else begin
            automatic int e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            chk(cyc == e, t, cyc, e);
         end
      end
      if (reset_req) width++;
      if (!reset_req && prev) begin
         chk(width == HOLD, "R8 reset pulse width", width, HOLD);
         width = 0;
      end
      prev = reset_req;
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_period(input logic [7:0] v);
      @(negedge clk); period_wr = 1'b1; period_data = v;
      @(negedge clk); period_wr = 1'b0;
   endtask

   // driver: writes key; pushes expected rise if units > 0
   task automatic put_key(input logic [7:0] v, input int units, input string t);
      @(negedge clk);
      key_wr = 1'b1; key_data = v;
      if (units > 0) begin exp_q.push_back(cyc + 1 + units*PRE); tag_q.push_back(t); end
      @(negedge clk); key_wr = 1'b0;
   endtask

   task automatic do_kick(input int units, input string t);
      @(negedge clk);
      kick = 1'b1;
      if (units > 0) begin exp_q.push_back(cyc + 1 + units*PRE); tag_q.push_back(t); end
      @(negedge clk); kick = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
      chk(wd_armed == 0,   "R1 armed after reset", wd_armed, 0);
      chk(aux_enable == 0, "R1 aux after reset", aux_enable, 0);
      chk(reset_req == 0,  "R1 reset_req after reset", reset_req, 0);

      // R5 basic expiry with period 5
      set_period(8'd5);
      put_key(8'hA5, 5, "R5 expiry after 5 units");
      chk(wd_armed == 1, "R2 armed after key", wd_armed, 1);
      wait_cyc(30);
      chk(wd_armed == 0, "R8 disarmed after expiry", wd_armed, 0);
      // R7 kick while disarmed ignored, R8 no re-fire
      do_kick(0, "");
      wait_cyc(40);
      chk(wd_armed == 0, "R7 kick while disarmed keeps disarmed", wd_armed, 0);

      // R6 zero period -> 7 units
      set_period(8'd0);
      put_key(8'hA5, 7, "R6 zero period gives 7 units");
      wait_cyc(35);

      // R7 kick restarts
      set_period(8'd3);
      put_key(8'hA5, 0, "");
      wait_cyc(8);
      do_kick(3, "R7 kick restarts countdown");
      wait_cyc(20);

      // R2 rearm restarts
      set_period(8'd2);
      put_key(8'hA5, 0, "");
      wait_cyc(5);
      put_key(8'hA5, 2, "R2 rearm restarts countdown");
      wait_cyc(15);

      // R9 period write mid-count
      put_key(8'hA5, 2, "R9 running count keeps old period");
      wait_cyc(2);
      set_period(8'd9);
      wait_cyc(12);
      put_key(8'hA5, 9, "R9 new period on next arming");
      wait_cyc(45);

      // R3 aux key
      put_key(8'hE5, 0, "");
      chk(aux_enable == 1, "R3 aux set by E5", aux_enable, 1);
      chk(wd_armed == 0,   "R3 E5 does not arm", wd_armed, 0);
      wait_cyc(40);
      put_key(8'h00, 0, "");
      chk(aux_enable == 0, "R4 aux cleared by 00", aux_enable, 0);

      // R4 other key disarms at once
      set_period(8'd5);
      put_key(8'hA5, 0, "");
      wait_cyc(3);
      put_key(8'h3C, 0, "");
      chk(wd_armed == 0, "R4 3C disarms", wd_armed, 0);
      wait_cyc(30);

      chk(exp_q.size() == 0, "R5 all expected reset requests seen", exp_q.size(), 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule